// File: doc/BRIEF.md
# Inter-Port Mailbox Interrupt Controller

This block gives two processors, attached to ports A and B, a small set of message registers kept apart from any shared memory. Each port owns a row of mailboxes that it alone may write. The other port may read that row but never change it. When a port stores into the high byte of one of its mailboxes, an interrupt source toward the other port becomes pending. The other port acknowledges by reading the high byte of that same mailbox. The read leaves the stored word unchanged.

Every receiving port has a mask register with one bit per source. It also has two read-only views of its incoming sources. The status view lists every pending source whatever the mask says. The cause view is a latched record that only an unmasked set event updates. Each port has an active-low interrupt output. It is low while any pending source aimed at that port is unmasked.

A port reaches its register space only when its mailbox select is low and its memory chip enable is high (inactive). Read data is registered: it appears on the port's read-data bus one clock after the read and holds until the next valid read on that port.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After a synchronous reset every mailbox, pending source, cause bit and mask bit is zero, and both interrupt outputs are high.
- R2: A port's access takes effect only in a cycle with sel_n low and ce_n high. Any other cycle changes no mailbox, mask, source or read data on that port.
- R3: Addresses 0 to 3 are the port's own mailboxes 0 to 3. On a write, be[0] stores bits 7:0 and be[1] stores bits 15:8, and a read returns the stored word.
- R4: Addresses 4 to 7 read mailboxes 0 to 3 of the other port. A write to addresses 4 to 7 changes nothing.
- R5: A write to own mailbox i with be[1] set makes source i toward the other port pending. A write with be = 2'b01 stores data and raises nothing.
- R6: A read of address 4+i with be[1] set clears the pending source i aimed at the reader and leaves mailbox i of the writer unchanged. A read with be[1] clear does not clear it.
- R7: If a set and a clear hit the same source in one cycle, the source stays pending.
- R8: Address 10 is the port's mask register in bits 3:0, written when be[0] is set. A 1 in bit i masks incoming source i.
- R9: The cause register at address 8 sets bit i only on a set event of source i while bit i is unmasked. It clears bit i when source i is cleared. Unmasking a source that is already pending leaves its cause bit at 0.
- R10: The status register at address 9 shows in bit i whether incoming source i is pending, whatever the mask.
- R11: A port's irq_n output is low exactly while some incoming source is both pending and unmasked.
- R12: Read data appears on rdata one clock after a valid read and is held until the next valid read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel_n | input | 1 | Port A mailbox select, active low |
| a_ce_n | input | 1 | Port A memory chip enable; must be high for mailbox access |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_be | input | 2 | Port A byte enables (bit 1 = high byte) |
| a_addr | input | 4 | Port A register address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A registered read data |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_sel_n | input | 1 | Port B mailbox select, active low |
| b_ce_n | input | 1 | Port B memory chip enable; must be high for mailbox access |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_be | input | 2 | Port B byte enables (bit 1 = high byte) |
| b_addr | input | 4 | Port B register address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B registered read data |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
The properties take a port's strobes to count only when that port is selected with its chip enable high. A cycle with both a_wr and a_rd set is treated as a write. Several checks rely on the other port leaving the same mailbox row alone in that cycle, so that a clear or a store can be attributed to one port. The bench drives at most one strobe per port per cycle and changes inputs only on falling edges. The set-versus-clear collision is the only cycle in which both ports touch the same source.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_NBOX = 4;
    localparam int MBX_DW   = 16;

    typedef enum logic [2:0] {
        RK_OWN,
        RK_PEER,
        RK_CAUSE,
        RK_STAT,
        RK_MASK,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        logic [1:0] be;
        reg_kind_e kind;
    } acc_t;

    // Map a register address onto its register class for a row of nbox mailboxes.
    function automatic reg_kind_e classify(input int unsigned a, input int unsigned nbox);
        if (a < nbox)               return RK_OWN;
        else if (a < 2 * nbox)      return RK_PEER;
        else if (a == 2 * nbox)     return RK_CAUSE;
        else if (a == 2 * nbox + 1) return RK_STAT;
        else if (a == 2 * nbox + 2) return RK_MASK;
        else                        return RK_NONE;
    endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int NBOX = MBX_NBOX,
    parameter int AW   = 4,
    parameter int IW   = 2
) (
    input  logic          sel_n,
    input  logic          ce_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    be,
    input  logic [AW-1:0] addr,
    output acc_t          acc,
    output logic [IW-1:0] idx
);
    logic        valid;
    int unsigned ai;
    int unsigned off;

    assign valid = !sel_n && ce_n;

    always_comb begin
        ai       = int'(addr);
        acc.kind = classify(ai, NBOX);
        acc.wr   = valid && wr;
        acc.rd   = valid && rd && !wr;
        acc.be   = be;
        off      = (ai >= NBOX) ? (ai - NBOX) : ai;
        idx      = IW'(off);
    end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
    parameter int NBOX = 4,
    parameter int DW   = 16,
    parameter int IW   = 2,
    localparam int HW  = DW / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IW-1:0]      idx,
    input  logic [1:0]         be,
    input  logic [DW-1:0]      wdata,
    output logic [NBOX*DW-1:0] boxes
);
    for (genvar g = 0; g < NBOX; g++) begin : g_box
        logic [DW-1:0] word_q;
        logic          hit;

        assign hit = wr_en && (idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (hit) begin
                if (be[0]) word_q[HW-1:0]  <= wdata[HW-1:0];
                if (be[1]) word_q[DW-1:HW] <= wdata[DW-1:HW];
            end
        end

        assign boxes[g*DW +: DW] = word_q;
    end

endmodule

// File: rtl/mbx_irq_src.sv
module mbx_irq_src #(
    parameter int NBOX = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NBOX-1:0] set_ev,
    input  logic [NBOX-1:0] clr_ev,
    input  logic            mask_we,
    input  logic [NBOX-1:0] mask_d,
    output logic [NBOX-1:0] pend,
    output logic [NBOX-1:0] cause,
    output logic [NBOX-1:0] mask,
    output logic            irq_n
);
    for (genvar g = 0; g < NBOX; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g]  <= 1'b0;
                cause[g] <= 1'b0;
            end else begin
                // a set in the same cycle as a clear keeps the source pending
                if (set_ev[g])      pend[g] <= 1'b1;
                else if (clr_ev[g]) pend[g] <= 1'b0;

                if (set_ev[g] && !mask[g]) cause[g] <= 1'b1;
                else if (clr_ev[g] && !set_ev[g]) cause[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)          mask[g] <= 1'b0;
            else if (mask_we) mask[g] <= mask_d[g];
        end
    end

    assign irq_n = ~|(pend & ~mask);

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int  NBOX = MBX_NBOX,
    parameter int  DW   = MBX_DW,
    localparam int AW   = $clog2(2 * NBOX + 3),
    localparam int IW   = $clog2(NBOX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_sel_n,
    input  logic          a_ce_n,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [1:0]    a_be,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq_n,
    input  logic          b_sel_n,
    input  logic          b_ce_n,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [1:0]    b_be,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq_n
);
    // index 0 is port A, index 1 is port B
    logic               sel_n_v [2];
    logic               ce_n_v  [2];
    logic               wr_v    [2];
    logic               rd_v    [2];
    logic [1:0]         be_v    [2];
    logic [AW-1:0]      addr_v  [2];
    logic [DW-1:0]      wdata_v [2];

    acc_t               acc     [2];
    logic [IW-1:0]      idx     [2];
    logic [NBOX*DW-1:0] boxes   [2];
    logic [NBOX-1:0]    pend    [2];
    logic [NBOX-1:0]    cause   [2];
    logic [NBOX-1:0]    mask    [2];
    logic [NBOX-1:0]    set_ev  [2];
    logic [NBOX-1:0]    clr_ev  [2];
    logic               irq_n_v [2];
    logic [DW-1:0]      rmux    [2];
    logic [DW-1:0]      rdata_q [2];

    assign sel_n_v[0] = a_sel_n;  assign sel_n_v[1] = b_sel_n;
    assign ce_n_v[0]  = a_ce_n;   assign ce_n_v[1]  = b_ce_n;
    assign wr_v[0]    = a_wr;     assign wr_v[1]    = b_wr;
    assign rd_v[0]    = a_rd;     assign rd_v[1]    = b_rd;
    assign be_v[0]    = a_be;     assign be_v[1]    = b_be;
    assign addr_v[0]  = a_addr;   assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;  assign wdata_v[1] = b_wdata;

    for (genvar p = 0; p < 2; p++) begin : g_port
        localparam int Q = 1 - p;

        mbx_port_dec #(.NBOX(NBOX), .AW(AW), .IW(IW)) u_dec (
            .sel_n (sel_n_v[p]),
            .ce_n  (ce_n_v[p]),
            .wr    (wr_v[p]),
            .rd    (rd_v[p]),
            .be    (be_v[p]),
            .addr  (addr_v[p]),
            .acc   (acc[p]),
            .idx   (idx[p])
        );

        logic own_wr;
        logic mask_we;
        assign own_wr  = acc[p].wr && (acc[p].kind == RK_OWN);
        assign mask_we = acc[p].wr && (acc[p].kind == RK_MASK) && acc[p].be[0];

        mbx_bank #(.NBOX(NBOX), .DW(DW), .IW(IW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (own_wr),
            .idx   (idx[p]),
            .be    (be_v[p]),
            .wdata (wdata_v[p]),
            .boxes (boxes[p])
        );

        // sources aimed at port p: set by the other port's high-byte stores,
        // cleared by port p's high-byte reads of the other port's row
        for (genvar g = 0; g < NBOX; g++) begin : g_ev
            assign set_ev[p][g] = acc[Q].wr && (acc[Q].kind == RK_OWN)
                                  && acc[Q].be[1] && (idx[Q] == IW'(g));
            assign clr_ev[p][g] = acc[p].rd && (acc[p].kind == RK_PEER)
                                  && acc[p].be[1] && (idx[p] == IW'(g));
        end

        mbx_irq_src #(.NBOX(NBOX)) u_src (
            .clk     (clk),
            .rst     (rst),
            .set_ev  (set_ev[p]),
            .clr_ev  (clr_ev[p]),
            .mask_we (mask_we),
            .mask_d  (wdata_v[p][NBOX-1:0]),
            .pend    (pend[p]),
            .cause   (cause[p]),
            .mask    (mask[p]),
            .irq_n   (irq_n_v[p])
        );

        always_comb begin
            rmux[p] = '0;
            case (acc[p].kind)
                RK_OWN:   rmux[p] = boxes[p][idx[p]*DW +: DW];
                RK_PEER:  rmux[p] = boxes[Q][idx[p]*DW +: DW];
                RK_CAUSE: rmux[p][NBOX-1:0] = cause[p];
                RK_STAT:  rmux[p][NBOX-1:0] = pend[p];
                RK_MASK:  rmux[p][NBOX-1:0] = mask[p];
                default:  rmux[p] = '0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)            rdata_q[p] <= '0;
            else if (acc[p].rd) rdata_q[p] <= rmux[p];
        end
    end

    assign a_rdata = rdata_q[0];
    assign b_rdata = rdata_q[1];
    assign a_irq_n = irq_n_v[0];
    assign b_irq_n = irq_n_v[1];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int NBOX = 4,
    parameter int DW   = 16,
    parameter int AW   = 4,
    parameter int IW   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               a_sel_n,
    input logic               a_ce_n,
    input logic               a_wr,
    input logic               a_rd,
    input logic [1:0]         a_be,
    input logic [AW-1:0]      a_addr,
    input logic [DW-1:0]      a_rdata,
    input logic               a_irq_n,
    input logic               b_sel_n,
    input logic               b_ce_n,
    input logic               b_wr,
    input logic [1:0]         b_be,
    input logic [AW-1:0]      b_addr,
    input logic               b_irq_n,
    input logic [NBOX*DW-1:0] boxes [2],
    input logic [NBOX-1:0]    pend  [2],
    input logic [NBOX-1:0]    cause [2],
    input logic [NBOX-1:0]    mask  [2]
);
    logic          a_ok, b_ok;
    logic          b_own, a_peer;
    logic [IW-1:0] b_idx, a_pidx;

    assign a_ok   = !a_sel_n && a_ce_n;
    assign b_ok   = !b_sel_n && b_ce_n;
    assign b_own  = int'(b_addr) < NBOX;
    assign a_peer = (int'(a_addr) >= NBOX) && (int'(a_addr) < 2 * NBOX);
    assign b_idx  = b_addr[IW-1:0];
    assign a_pidx = IW'(int'(a_addr) - NBOX);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (a_irq_n && b_irq_n));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !a_ok |=> ($stable(a_rdata) && $stable(mask[0]) && $stable(boxes[0])));

    p_peer_row_ro_r4: assert property (@(posedge clk) disable iff (rst)
        (a_ok && a_peer && !(b_ok && b_wr)) |=> $stable(boxes[1]));

    p_high_store_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (b_ok && b_wr && b_own && b_be[1]) |=> pend[0][$past(b_idx)]);

    p_low_store_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (b_ok && b_wr && b_own && (b_be == 2'b01) && !a_ok) |=> (pend[0] == $past(pend[0])));

    p_high_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (a_ok && a_rd && !a_wr && a_peer && a_be[1] && !(b_ok && b_wr))
        |=> !pend[0][$past(a_pidx)]);

    p_cause_within_status_r9: assert property (@(posedge clk) disable iff (rst)
        ((cause[0] & ~pend[0]) == '0) && ((cause[1] & ~pend[1]) == '0));

endmodule

bind mbx_irq_ctrl mbx_irq_chk #(.NBOX(NBOX), .DW(DW), .AW(AW), .IW(IW)) u_chk (.*);

// File: tb/sim_mbx_irq_ctrl.sv
module sim_mbx_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_sel_n, a_ce_n, a_wr, a_rd;
    logic [1:0]  a_be;
    logic [3:0]  a_addr;
    logic [15:0] a_wdata, a_rdata;
    logic        a_irq_n;
    logic        b_sel_n, b_ce_n, b_wr, b_rd;
    logic [1:0]  b_be;
    logic [3:0]  b_addr;
    logic [15:0] b_wdata, b_rdata;
    logic        b_irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbx_irq_ctrl u0 (.*);

    task automatic idle();
        a_sel_n = 1'b1; a_ce_n = 1'b1; a_wr = 1'b0; a_rd = 1'b0;
        a_be = 2'b00; a_addr = '0; a_wdata = '0;
        b_sel_n = 1'b1; b_ce_n = 1'b1; b_wr = 1'b0; b_rd = 1'b0;
        b_be = 2'b00; b_addr = '0; b_wdata = '0;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input bit p, input bit sn, input bit cn, input bit w, input bit r,
                       input logic [3:0] ad, input logic [1:0] be, input logic [15:0] d);
        if (!p) begin
            a_sel_n = sn; a_ce_n = cn; a_wr = w; a_rd = r; a_addr = ad; a_be = be; a_wdata = d;
        end else begin
            b_sel_n = sn; b_ce_n = cn; b_wr = w; b_rd = r; b_addr = ad; b_be = be; b_wdata = d;
        end
    endtask

    task automatic step(input bit p, output logic [15:0] q);
        @(negedge clk);
        q = p ? b_rdata : a_rdata;
        idle();
    endtask

    task automatic wr(input bit p, input logic [3:0] ad, input logic [1:0] be, input logic [15:0] d);
        logic [15:0] q;
        put(p, 1'b0, 1'b1, 1'b1, 1'b0, ad, be, d);
        step(p, q);
    endtask

    task automatic rd(input bit p, input logic [3:0] ad, input logic [1:0] be, output logic [15:0] q);
        put(p, 1'b0, 1'b1, 1'b0, 1'b1, ad, be, '0);
        step(p, q);
    endtask

    task automatic t_reset();
        logic [15:0] q;
        chk("R1", "a_irq_n", 16'(a_irq_n), 16'h1);
        chk("R1", "b_irq_n", 16'(b_irq_n), 16'h1);
        chk("R1", "a_rdata", a_rdata, 16'h0);
        rd(0, 4'd9, 2'b01, q);  chk("R1", "A status", q, 16'h0);
        rd(0, 4'd10, 2'b01, q); chk("R1", "A mask", q, 16'h0);
        rd(1, 4'd2, 2'b01, q);  chk("R1", "B box2", q, 16'h0);
    endtask

    task automatic t_lanes();
        logic [15:0] q;
        wr(0, 4'd1, 2'b01, 16'hCDAB);
        rd(0, 4'd1, 2'b00, q);  chk("R3", "A box1 low lane", q, 16'h00AB);
        chk("R5", "b_irq_n after low store", 16'(b_irq_n), 16'h1);
        rd(1, 4'd9, 2'b01, q);  chk("R5", "B status after low store", q, 16'h0);
        wr(0, 4'd1, 2'b10, 16'h1299);
        chk("R11", "b_irq_n after high store", 16'(b_irq_n), 16'h0);
        rd(0, 4'd1, 2'b00, q);  chk("R3", "A box1 both lanes", q, 16'h12AB);
        rd(1, 4'd9, 2'b01, q);  chk("R10", "B status", q, 16'h0002);
        rd(1, 4'd8, 2'b01, q);  chk("R9", "B cause", q, 16'h0002);
    endtask

    task automatic t_ack();
        logic [15:0] q;
        rd(1, 4'd5, 2'b01, q);  chk("R4", "B reads A box1", q, 16'h12AB);
        rd(1, 4'd9, 2'b01, q);  chk("R6", "status after low-lane read", q, 16'h0002);
        rd(1, 4'd5, 2'b10, q);  chk("R6", "ack read data", q, 16'h12AB);
        chk("R11", "b_irq_n after ack", 16'(b_irq_n), 16'h1);
        rd(1, 4'd9, 2'b01, q);  chk("R6", "status after ack", q, 16'h0);
        rd(1, 4'd8, 2'b01, q);  chk("R9", "cause after ack", q, 16'h0);
        rd(0, 4'd1, 2'b00, q);  chk("R6", "A box1 kept", q, 16'h12AB);
        wr(1, 4'd2, 2'b11, 16'hBEEF);
        chk("R11", "a_irq_n after B store", 16'(a_irq_n), 16'h0);
        rd(0, 4'd6, 2'b11, q);  chk("R4", "A reads B box2", q, 16'hBEEF);
        chk("R6", "a_irq_n after ack", 16'(a_irq_n), 16'h1);
    endtask

    task automatic t_peer_write();
        logic [15:0] q;
        wr(1, 4'd6, 2'b11, 16'hFFFF);
        rd(0, 4'd2, 2'b00, q);  chk("R4", "A box2 after B peer write", q, 16'h0);
        rd(0, 4'd9, 2'b01, q);  chk("R4", "A status after B peer write", q, 16'h0);
        chk("R4", "a_irq_n after B peer write", 16'(a_irq_n), 16'h1);
    endtask

    task automatic t_gate();
        logic [15:0] q;
        put(0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 2'b11, 16'hFFFF); step(0, q);
        put(0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 2'b11, 16'hFFFF); step(0, q);
        chk("R2", "b_irq_n after gated stores", 16'(b_irq_n), 16'h1);
        rd(0, 4'd1, 2'b00, q);  chk("R12", "A box1 read", q, 16'h12AB);
        put(0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 2'b00, '0); step(0, q);
        chk("R2", "rdata held on deselected read", q, 16'h12AB);
        put(0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 2'b00, '0); step(0, q);
        chk("R12", "rdata held with ce_n low", q, 16'h12AB);
        rd(0, 4'd0, 2'b00, q);  chk("R2", "A box0 untouched", q, 16'h0);
    endtask

    task automatic t_mask();
        logic [15:0] q;
        wr(1, 4'd10, 2'b01, 16'h0001);
        rd(1, 4'd10, 2'b01, q); chk("R8", "B mask", q, 16'h0001);
        wr(0, 4'd0, 2'b10, 16'h5500);
        chk("R11", "b_irq_n masked", 16'(b_irq_n), 16'h1);
        rd(1, 4'd9, 2'b01, q);  chk("R10", "B status masked", q, 16'h0001);
        rd(1, 4'd8, 2'b01, q);  chk("R9", "B cause masked", q, 16'h0);
        wr(1, 4'd10, 2'b01, 16'h0000);
        chk("R11", "b_irq_n after unmask", 16'(b_irq_n), 16'h0);
        rd(1, 4'd8, 2'b01, q);  chk("R9", "B cause after unmask", q, 16'h0);
        rd(1, 4'd4, 2'b10, q);  chk("R6", "B ack box0", q, 16'h5500);
        rd(1, 4'd9, 2'b01, q);  chk("R10", "B status cleared", q, 16'h0);
        chk("R11", "b_irq_n cleared", 16'(b_irq_n), 16'h1);
    endtask

    task automatic t_collide();
        logic [15:0] q;
        wr(0, 4'd3, 2'b10, 16'h7700);
        put(0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 2'b10, 16'h8800);
        put(1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7, 2'b10, '0);
        step(1, q);
        chk("R7", "B read data in collision", q, 16'h7700);
        rd(1, 4'd9, 2'b01, q);  chk("R7", "source still pending", q, 16'h0008);
        chk("R7", "b_irq_n after collision", 16'(b_irq_n), 16'h0);
        rd(1, 4'd7, 2'b10, q);  chk("R6", "later ack data", q, 16'h8800);
        rd(1, 4'd9, 2'b01, q);  chk("R6", "status after later ack", q, 16'h0);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lanes();
        t_ack();
        t_peer_write();
        t_gate();
        t_mask();
        t_collide();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule